// File: doc/BRIEF.md
# Jitter Distribution Sweep Controller

This block runs a delay-tap sweep that turns a stream of single-bit samples into a cumulative error distribution. Each sample comes from a capture flop that samples a reference pattern through a tapped delay. The block drives `tap_sel` to choose the tap. It compares every accepted sample with the value the reference should have carried. It counts the mismatches over a window of `WIN_LEN` accepted samples and then moves to the next tap.

The sweep starts at tap 0, the shortest delay, where no errors are expected. The sweep ends after the window at the last tap. For each window the block compares the error count with two per-mille thresholds, which give the lower and upper edges of the distribution (159/841 gives the one-sigma points). It also tracks the first tap with any error and the first tap where every sample is wrong, which gives the peak-to-peak extent. A threshold that is never crossed sets an overflow flag.

The reference can be a plain clock, where the expected value is always 1. It can also be a pseudo-random stream, where a local LFSR produces the expected value. The sample input is a valid/ready stream. `samp_ready` is high only while a sweep runs, and a sample counts only in a cycle where `samp_valid` and `samp_ready` are both high. The producer may hold `samp_valid` low for any number of cycles. No sample is buffered.

Top module: `jitter_sweep_ctrl`

## Requirements
- R1: After reset `busy`, `done`, `samp_ready`, `win_err_valid` and all bits of `tap_ovf` are 0, and `tap_sel` is 0.
- R2: A `start` pulse while not busy clears `done` and all results, sets `tap_sel` to 0, and raises `samp_ready` in the next cycle. A `start` pulse while busy is ignored.
- R3: Every `WIN_LEN` accepted samples, `win_err_valid` pulses for one cycle, in the cycle after the last accepted sample of the window. `win_err` then holds the number of mismatches in that window. Cycles without acceptance do not count.
- R4: `tap_sel` advances by one at the end of each window. After the window at tap `NTAPS-1` the sweep stops: `samp_ready` falls, `tap_sel` stays at `NTAPS-1`, and `done` rises two cycles after the last accepted sample.
- R5: With `mode`=0 the expected value is 1. With `mode`=1 the expected value is bit 6 of a 7-bit LFSR. The LFSR is loaded with 7'b1111111 at start, and on each accepted sample it steps from s to {s[5:0], s[6]^s[5]}.
- R6: `tap_lo` is the first tap whose window count e satisfies e*1000 >= `lo_pm`*`WIN_LEN`.
- R7: `tap_hi` is the first tap whose window count e satisfies e*1000 >= `hi_pm`*`WIN_LEN`.
- R8: `tap_first` is the first tap whose window count is non-zero.
- R9: `tap_full` is the first tap whose window count equals `WIN_LEN`.
- R10: `tap_ovf` bit 0 (lo), bit 1 (hi), bit 2 (first) and bit 3 (full) are each set when the sweep ends without that condition met. The matching tap output then reads 0.
- R11: `mode`, `lo_pm` and `hi_pm` are captured at start. Changing them during a sweep has no effect on that sweep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a sweep when idle |
| mode | input | 1 | 0 = clock reference, 1 = pseudo-random reference |
| lo_pm | input | 10 | Lower threshold in per-mille |
| hi_pm | input | 10 | Upper threshold in per-mille |
| samp_valid | input | 1 | Sample present |
| samp_bit | input | 1 | Captured sample value |
| samp_ready | output | 1 | Sample accepted this cycle when valid |
| tap_sel | output | $clog2(NTAPS) | Delay tap selection |
| win_err | output | $clog2(WIN_LEN+1) | Mismatch count of the last window |
| win_err_valid | output | 1 | One-cycle pulse when `win_err` updates |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | Sweep complete, results valid |
| tap_lo | output | $clog2(NTAPS) | Lower threshold tap |
| tap_hi | output | $clog2(NTAPS) | Upper threshold tap |
| tap_first | output | $clog2(NTAPS) | First tap with errors |
| tap_full | output | $clog2(NTAPS) | First tap with all samples wrong |
| tap_ovf | output | 4 | Per-threshold overflow flags |

## Verification
The sweep is tried with four jitter shapes. A uniform spread in the middle of the tap range with clock reference places all four crossings inside the sweep. A scrambled spread with pseudo-random reference and gaps in `samp_valid` shows whether the LFSR advances only on accepted samples and whether windows count only accepted samples. A late spread pushes the upper and full crossings past the last tap, which exercises the overflow flags. A zero-width spread makes all four crossings fall on tap 1 together. In the first run a start pulse and changed threshold and mode inputs arrive during the sweep, which separates captured settings from live ones.

// File: rtl/jsw_pkg.sv
package jsw_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FINISH} sweep_st_t;

  localparam int LFSR_W = 7;
  localparam logic [LFSR_W-1:0] LFSR_SEED = '1;
  localparam int PM_W = 10;
  localparam int PM_SCALE = 1000;
  localparam int N_CROSS = 4;
  localparam int X_LO = 0;
  localparam int X_HI = 1;
  localparam int X_FIRST = 2;
  localparam int X_FULL = 3;

  function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
    return {s[LFSR_W-2:0], s[LFSR_W-1] ^ s[LFSR_W-2]};
  endfunction
endpackage

// File: rtl/jsw_lfsr.sv
module jsw_lfsr
  import jsw_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic adv,
  output logic bit_out
);
  logic [LFSR_W-1:0] st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    st <= LFSR_SEED;
    else if (load) st <= LFSR_SEED;
    else if (adv)  st <= lfsr_step(st);
  end

  assign bit_out = st[LFSR_W-1];
endmodule

// File: rtl/jsw_window.sv
module jsw_window #(
  parameter int WIN_LEN = 8096,
  localparam int CW = $clog2(WIN_LEN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          acc,
  input  logic          mis,
  output logic          wrap,
  output logic [CW-1:0] err_total
);
  logic [CW-1:0] smp_cnt;
  logic [CW-1:0] err_cnt;
  logic          at_end;

  assign at_end    = (smp_cnt == CW'(WIN_LEN - 1));
  assign wrap      = acc && at_end;
  assign err_total = err_cnt + CW'(mis);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_cnt <= '0;
      err_cnt <= '0;
    end else if (clr || wrap) begin
      smp_cnt <= '0;
      err_cnt <= '0;
    end else if (acc) begin
      smp_cnt <= smp_cnt + 1'b1;
      err_cnt <= err_total;
    end
  end
endmodule

// File: rtl/jsw_cross.sv
module jsw_cross #(
  parameter int TAP_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             eval,
  input  logic             hit,
  input  logic             last,
  input  logic [TAP_W-1:0] tap,
  output logic [TAP_W-1:0] tap_q,
  output logic             ovf
);
  logic found;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      found <= 1'b0;
      tap_q <= '0;
      ovf   <= 1'b0;
    end else if (clr) begin
      found <= 1'b0;
      tap_q <= '0;
      ovf   <= 1'b0;
    end else if (eval && !found && !ovf) begin
      if (hit) begin
        found <= 1'b1;
        tap_q <= tap;
      end else if (last) begin
        ovf <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/jitter_sweep_ctrl.sv
module jitter_sweep_ctrl
  import jsw_pkg::*;
#(
  parameter int NTAPS = 32,
  parameter int WIN_LEN = 8096,
  localparam int TAP_W = $clog2(NTAPS),
  localparam int CW = $clog2(WIN_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             mode,
  input  logic [9:0]       lo_pm,
  input  logic [9:0]       hi_pm,
  input  logic             samp_valid,
  input  logic             samp_bit,
  output logic             samp_ready,
  output logic [TAP_W-1:0] tap_sel,
  output logic [CW-1:0]    win_err,
  output logic             win_err_valid,
  output logic             busy,
  output logic             done,
  output logic [TAP_W-1:0] tap_lo,
  output logic [TAP_W-1:0] tap_hi,
  output logic [TAP_W-1:0] tap_first,
  output logic [TAP_W-1:0] tap_full,
  output logic [3:0]       tap_ovf
);
  localparam int PROD_W = CW + PM_W + 1;
  localparam logic [TAP_W-1:0] LAST_TAP = TAP_W'(NTAPS - 1);

  sweep_st_t        state;
  logic             mode_q;
  logic [PM_W-1:0]  lo_q, hi_q;
  logic [TAP_W-1:0] tap;
  logic [TAP_W-1:0] win_tap;
  logic             clr, acc, mis, exp_bit, prbs_bit, wrap;
  logic [CW-1:0]    err_total;

  assign clr        = (state == ST_IDLE) && start;
  assign samp_ready = (state == ST_RUN);
  assign acc        = samp_valid && samp_ready;
  assign exp_bit    = mode_q ? prbs_bit : 1'b1;
  assign mis        = (samp_bit != exp_bit);
  assign busy       = (state != ST_IDLE);
  assign tap_sel    = tap;

  jsw_lfsr u_lfsr (
    .clk(clk), .rst_n(rst_n), .load(clr), .adv(acc), .bit_out(prbs_bit)
  );

  jsw_window #(.WIN_LEN(WIN_LEN)) u_win (
    .clk(clk), .rst_n(rst_n), .clr(clr), .acc(acc), .mis(mis),
    .wrap(wrap), .err_total(err_total)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state         <= ST_IDLE;
      tap           <= '0;
      win_tap       <= '0;
      win_err       <= '0;
      win_err_valid <= 1'b0;
      done          <= 1'b0;
      mode_q        <= 1'b0;
      lo_q          <= '0;
      hi_q          <= '0;
    end else begin
      win_err_valid <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          state  <= ST_RUN;
          tap    <= '0;
          done   <= 1'b0;
          mode_q <= mode;
          lo_q   <= lo_pm;
          hi_q   <= hi_pm;
        end
        ST_RUN: if (wrap) begin
          win_err       <= err_total;
          win_err_valid <= 1'b1;
          win_tap       <= tap;
          if (tap == LAST_TAP) state <= ST_FINISH;
          else                 tap   <= tap + 1'b1;
        end
        ST_FINISH: begin
          state <= ST_IDLE;
          done  <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  logic [PROD_W-1:0] err_scaled, lo_thr, hi_thr;
  logic [N_CROSS-1:0] hit;
  logic [TAP_W-1:0]   cross_tap [N_CROSS];

  assign err_scaled = PROD_W'(win_err) * PROD_W'(PM_SCALE);
  assign lo_thr     = PROD_W'(lo_q) * PROD_W'(WIN_LEN);
  assign hi_thr     = PROD_W'(hi_q) * PROD_W'(WIN_LEN);

  always_comb begin
    hit[X_LO]    = (err_scaled >= lo_thr);
    hit[X_HI]    = (err_scaled >= hi_thr);
    hit[X_FIRST] = (win_err != '0);
    hit[X_FULL]  = (win_err == CW'(WIN_LEN));
  end

  for (genvar i = 0; i < N_CROSS; i++) begin : g_cross
    jsw_cross #(.TAP_W(TAP_W)) u_cross (
      .clk(clk), .rst_n(rst_n), .clr(clr), .eval(win_err_valid),
      .hit(hit[i]), .last(win_tap == LAST_TAP), .tap(win_tap),
      .tap_q(cross_tap[i]), .ovf(tap_ovf[i])
    );
  end

  assign tap_lo    = cross_tap[X_LO];
  assign tap_hi    = cross_tap[X_HI];
  assign tap_first = cross_tap[X_FIRST];
  assign tap_full  = cross_tap[X_FULL];
endmodule

// File: rtl/jitter_sweep_ctrl_chk.sv
module jitter_sweep_ctrl_chk #(
  parameter int NTAPS = 32,
  parameter int WIN_LEN = 8096,
  localparam int TAP_W = $clog2(NTAPS),
  localparam int CW = $clog2(WIN_LEN + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             samp_valid,
  input logic             samp_ready,
  input logic [TAP_W-1:0] tap_sel,
  input logic [CW-1:0]    win_err,
  input logic             win_err_valid,
  input logic             busy,
  input logic             done,
  input logic [TAP_W-1:0] tap_first,
  input logic [TAP_W-1:0] tap_full,
  input logic [3:0]       tap_ovf
);
  assert_idle_no_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !samp_ready);

  assert_win_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    win_err_valid |-> (win_err <= CW'(WIN_LEN)));

  assert_win_after_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    win_err_valid |-> $past(samp_valid && samp_ready));

  assert_tap_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tap_sel != $past(tap_sel)) |-> (tap_sel == $past(tap_sel) + 1'b1 || tap_sel == '0));

  assert_done_not_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !samp_ready);

  assert_ovf_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> $stable(tap_ovf));

  assert_first_not_after_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !tap_ovf[2] && !tap_ovf[3]) |-> (tap_first <= tap_full));
endmodule

bind jitter_sweep_ctrl jitter_sweep_ctrl_chk #(.NTAPS(NTAPS), .WIN_LEN(WIN_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .samp_valid(samp_valid),
  .samp_ready(samp_ready), .tap_sel(tap_sel), .win_err(win_err),
  .win_err_valid(win_err_valid), .busy(busy), .done(done),
  .tap_first(tap_first), .tap_full(tap_full), .tap_ovf(tap_ovf)
);

// File: tb/jitter_sweep_ctrl_test.sv
module jitter_sweep_ctrl_test;
  localparam int NT = 16;
  localparam int E  = 20;
  localparam int TW = $clog2(NT);
  localparam int CW = $clog2(E + 1);

  logic clk = 0, rst_n = 0, start = 0, mode = 0;
  logic [9:0] lo_pm = 0, hi_pm = 0;
  logic samp_valid, samp_bit, samp_ready, win_err_valid, busy, done;
  logic [TW-1:0] tap_sel, tap_lo, tap_hi, tap_first, tap_full;
  logic [CW-1:0] win_err;
  logic [3:0] tap_ovf;

  always #4 clk = ~clk;

  jitter_sweep_ctrl #(.NTAPS(NT), .WIN_LEN(E)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .lo_pm(lo_pm),
    .hi_pm(hi_pm), .samp_valid(samp_valid), .samp_bit(samp_bit),
    .samp_ready(samp_ready), .tap_sel(tap_sel), .win_err(win_err),
    .win_err_valid(win_err_valid), .busy(busy), .done(done),
    .tap_lo(tap_lo), .tap_hi(tap_hi), .tap_first(tap_first),
    .tap_full(tap_full), .tap_ovf(tap_ovf)
  );

  // behavioural reference, delay chain and capture flop
  int j_base = 0, j_mul = 1, j_spread = 1;
  logic b_mode = 0, gaps = 0;
  int k = 0, cyc = 0;
  logic [6:0] blfsr = 7'h7F;

  function automatic int jv(input int idx);
    return j_base + (idx * j_mul) % j_spread;
  endfunction

  always_comb begin
    logic rb;
    rb = b_mode ? blfsr[6] : 1'b1;
    samp_bit = (int'(tap_sel) > jv(k)) ? ~rb : rb;
    samp_valid = gaps ? (cyc % 3 != 0) : 1'b1;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (start && !busy) begin
      k <= 0;
      blfsr <= 7'h7F;
    end else if (samp_valid && samp_ready) begin
      k <= (k == E - 1) ? 0 : k + 1;
      blfsr <= {blfsr[5:0], blfsr[6] ^ blfsr[5]};
    end
  end

  int checks = 0, fails = 0, mon_checks = 0, mon_fails = 0;
  int exp_err [NT];
  int wcnt = 0, wbase = 0;

  task automatic chk(input string req, input int act, input int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && win_err_valid) begin
      int w;
      w = wcnt - wbase;
      mon_checks++;
      if (w >= NT || int'(win_err) != exp_err[w]) begin
        mon_fails++;
        $display("FAIL R3/R5 window %0d: actual %0d expected %0d",
                 w, win_err, (w < NT) ? exp_err[w] : -1);
      end
      wcnt++;
    end
  end

  task automatic sweep(input logic m, input int lo, input int hi,
                       input int b, input int mu, input int sp,
                       input logic g, input logic disturb);
    int el, eh, ef, eu;
    int tl, th, tf, tu;
    int n;
    j_base = b; j_mul = mu; j_spread = sp; b_mode = m; gaps = g;
    el = -1; eh = -1; ef = -1; eu = -1;
    for (int t = 0; t < NT; t++) begin
      int e;
      e = 0;
      for (int i = 0; i < E; i++) if (jv(i) < t) e++;
      exp_err[t] = e;
      if (el < 0 && e * 1000 >= lo * E) el = t;
      if (eh < 0 && e * 1000 >= hi * E) eh = t;
      if (ef < 0 && e != 0) ef = t;
      if (eu < 0 && e == E) eu = t;
    end
    @(negedge clk);
    wbase = wcnt;
    mode = m; lo_pm = 10'(lo); hi_pm = 10'(hi);
    start = 1;
    @(negedge clk);
    start = 0;
    chk("R2 ready after start", int'(samp_ready), 1);
    chk("R2 done cleared", int'(done), 0);
    if (disturb) begin
      repeat (30) @(negedge clk);
      start = 1; mode = ~m; lo_pm = 10'd999; hi_pm = 10'd1;
      @(negedge clk);
      start = 0;
      chk("R2 start while busy ignored", int'(busy), 1);
    end
    n = 0;
    while (!done && n < 20000) begin
      @(negedge clk);
      n++;
    end
    chk("R4 sweep completes", int'(done), 1);
    chk("R4 all windows seen", wcnt - wbase, NT);
    chk("R4 ready low at end", int'(samp_ready), 0);
    chk("R4 tap held at last", int'(tap_sel), NT - 1);
    tl = (el < 0) ? 0 : el; th = (eh < 0) ? 0 : eh;
    tf = (ef < 0) ? 0 : ef; tu = (eu < 0) ? 0 : eu;
    chk("R6 tap_lo", int'(tap_lo), tl);
    chk("R7 tap_hi", int'(tap_hi), th);
    chk("R8 tap_first", int'(tap_first), tf);
    chk("R9 tap_full", int'(tap_full), tu);
    chk("R10 overflow flags", int'(tap_ovf),
        int'({eu < 0, ef < 0, eh < 0, el < 0}));
    if (disturb) chk("R11 settings captured", int'(tap_lo), tl);
    mode = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 busy at reset", int'(busy), 0);
    chk("R1 done at reset", int'(done), 0);
    chk("R1 ready at reset", int'(samp_ready), 0);
    chk("R1 tap at reset", int'(tap_sel), 0);
    chk("R1 ovf at reset", int'(tap_ovf), 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 idle after reset", int'(win_err_valid), 0);
    sweep(1'b0, 159, 841, 4, 1, 8, 1'b0, 1'b1);
    sweep(1'b1, 100, 900, 2, 7, 11, 1'b1, 1'b0);
    sweep(1'b0, 200, 800, 12, 3, 8, 1'b0, 1'b0);
    sweep(1'b1, 500, 500, 0, 1, 1, 1'b1, 1'b0);
    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==",
             checks + mon_checks, fails + mon_fails);
    $finish;
  end

  initial begin
    #1500000;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==",
             checks + mon_checks + 1, fails + mon_fails + 1);
    $finish;
  end
endmodule